// File: doc/BRIEF.md
# CAN Error Flag and Code Capture Unit

This unit is the error reporting section of a CAN controller. The protocol engine sends it single-cycle pulses for individual error kinds: seven frame-level error codes and three bus-level events (overrun, overload frame sent, bus lock). It also supplies the live transmit and receive error counters. From these inputs the unit keeps an error code register and an error factor register. It derives the warning, passive, bus-off entry and bus-off recovery events from counter thresholds. It drives one interrupt line.

Software reaches the unit through a byte-wide register bus. Reads are combinational and writes take effect at the clock edge. A flag is cleared by writing 0 to its bit; writing 1 to a flag bit leaves it unchanged. A display-mode bit in the code register chooses how new errors are recorded. In accumulate mode new errors add to the bits already held. In latest-only mode each new error replaces the whole code field.

The register offsets are: 0 error code, 1 error factor, 2 factor enable, 3 interrupt enable, 4 interrupt status, 5 transmit counter, 6 receive counter.

Top module: `can_err_report`

## Requirements
- R1: After reset, every register reads 0x00 and `irq_o` is low.
- R2: In the code register (bits 6:0) and the factor register (bits 7:0), writing 0 to a bit clears that flag and writing 1 leaves it unchanged. The factor register changes only through a write or a new event.
- R3: When code register bit 7 is 1 (accumulate mode), each `code_pulse_i` bit sets the matching code bit and the other code bits are kept. The code bits are: 6 ACK delimiter, 5 dominant bit error, 4 recessive bit error, 3 CRC, 2 ACK, 1 form, 0 stuff.
- R4: When code register bit 7 is 0 (latest-only mode), any pulse replaces bits 6:0 with exactly the bits pulsed in that cycle.
- R5: Factor bit 0 (bus error) is set in the cycle after any `code_pulse_i` bit is high.
- R6: Factor bit 1 (warning) is set when the condition "either counter is at least 96" becomes true. The flag is not set again while the condition stays true.
- R7: Factor bit 2 (passive) is set when the condition "either counter is greater than 127" becomes true.
- R8: Factor bit 3 (bus-off entry) is set when `tec_i` goes above 255. Factor bit 4 (bus-off recovery) is set when `tec_i` drops back to 255 or below.
- R9: The bits of `event_pulse_i` set factor flags as follows: bit 0 (overrun) sets factor bit 5, bit 1 (overload frame sent) sets factor bit 6, and bit 2 (bus lock) sets factor bit 7.
- R10: When a set event and a clearing write hit the same bit in the same cycle, the bit ends set.
- R11: Status register bit 5 reads 1 exactly when some factor bit and its enable bit (same layout, offset 2) are both 1. `irq_o` equals that status bit gated by interrupt-enable bit 5 (offset 3).
- R12: Offset 5 reads the transmit counter, saturated to 0xFF when it is above 255. Offset 6 reads the receive counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_pulse_i | input | 7 | Error code pulses, bit layout as in the code register |
| event_pulse_i | input | 3 | Overrun (0), overload sent (1), bus lock (2) pulses |
| tec_i | input | 9 | Transmit error counter |
| rec_i | input | 8 | Receive error counter |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data (combinational) |
| irq_o | output | 1 | Error interrupt |

## Verification
A wrong internal state shows up in the next register read, one cycle after the event that caused it. Two cases are exercised directly.

- A stuck or lost flag is found by reading back after each clear. The interrupt output is also checked with the enables toggled.
- A wrong edge detector is found by holding a counter above a threshold, clearing the flag, and checking that the flag does not return.

Threshold boundaries are tested on both sides: 95 and 96, 127 and 128, 255 and 256. Same-cycle set-and-clear is also tested. Either fault changes the read value immediately.

// File: rtl/can_err_report.sv
module can_err_report #(
  parameter int WARN_LVL    = 96,
  parameter int PASSIVE_LVL = 127,
  parameter int BUSOFF_LVL  = 255
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [6:0] code_pulse_i,
  input  logic [2:0] event_pulse_i,
  input  logic [8:0] tec_i,
  input  logic [7:0] rec_i,
  input  logic       bus_we_i,
  input  logic [2:0] bus_addr_i,
  input  logic [7:0] bus_wdata_i,
  output logic [7:0] bus_rdata_o,
  output logic       irq_o
);

  logic       code_mode;
  logic [6:0] code_q;
  logic [7:0] factor_q, enable_q;
  logic       ie_q;
  logic       warn_q, pass_q, boff_q;

  logic warn_c, pass_c, boff_c, summary;
  logic wr_code, wr_fac, wr_en, wr_ie;
  logic [7:0] fac_set;

  assign warn_c = (int'(tec_i) >= WARN_LVL) || (int'(rec_i) >= WARN_LVL);
  assign pass_c = (int'(tec_i) > PASSIVE_LVL) || (int'(rec_i) > PASSIVE_LVL);
  assign boff_c = int'(tec_i) > BUSOFF_LVL;

  assign wr_code = bus_we_i && bus_addr_i == 3'd0;
  assign wr_fac  = bus_we_i && bus_addr_i == 3'd1;
  assign wr_en   = bus_we_i && bus_addr_i == 3'd2;
  assign wr_ie   = bus_we_i && bus_addr_i == 3'd3;

  assign fac_set = {event_pulse_i[2], event_pulse_i[1], event_pulse_i[0],
                    boff_q & ~boff_c, boff_c & ~boff_q,
                    pass_c & ~pass_q, warn_c & ~warn_q, |code_pulse_i};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_mode <= 1'b0;
      code_q    <= '0;
      factor_q  <= '0;
      enable_q  <= '0;
      ie_q      <= 1'b0;
      warn_q    <= 1'b0;
      pass_q    <= 1'b0;
      boff_q    <= 1'b0;
    end else begin
      warn_q <= warn_c;
      pass_q <= pass_c;
      boff_q <= boff_c;
      if (wr_code) code_mode <= bus_wdata_i[7];
      if ((|code_pulse_i) && !code_mode)
        code_q <= code_pulse_i;
      else
        code_q <= (code_q & (wr_code ? bus_wdata_i[6:0] : 7'h7f)) | code_pulse_i;
      factor_q <= (factor_q & (wr_fac ? bus_wdata_i : 8'hff)) | fac_set;
      if (wr_en) enable_q <= bus_wdata_i;
      if (wr_ie) ie_q <= bus_wdata_i[5];
    end
  end

  assign summary = |(factor_q & enable_q);
  assign irq_o   = summary & ie_q;

  always_comb begin
    case (bus_addr_i)
      3'd0:    bus_rdata_o = {code_mode, code_q};
      3'd1:    bus_rdata_o = factor_q;
      3'd2:    bus_rdata_o = enable_q;
      3'd3:    bus_rdata_o = {2'b00, ie_q, 5'b00000};
      3'd4:    bus_rdata_o = {2'b00, summary, 5'b00000};
      3'd5:    bus_rdata_o = tec_i[8] ? 8'hff : tec_i[7:0];
      3'd6:    bus_rdata_o = rec_i;
      default: bus_rdata_o = 8'h00;
    endcase
  end

  p_no_silent_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_fac |=> (factor_q & $past(factor_q)) == $past(factor_q));

  p_accumulate_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (code_mode && !wr_code) |=> (code_q & $past(code_q)) == $past(code_q));

  p_latest_replace_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|code_pulse_i) && !code_mode) |=> code_q == $past(code_pulse_i));

  p_bus_error_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|code_pulse_i) |=> factor_q[0]);

  p_busoff_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tec_i > 9'd255) |=> factor_q[3]);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|event_pulse_i) |=> (factor_q[7:5] & $past(event_pulse_i)) == $past(event_pulse_i));

  p_irq_needs_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (factor_q == 8'h00) |-> !irq_o);

endmodule

// File: tb/sim_can_err_report.sv
module sim_can_err_report;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] code_pulse = '0;
  logic [2:0] ev_pulse = '0;
  logic [8:0] tec = '0;
  logic [7:0] rec = '0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  can_err_report u0 (
    .clk(clk), .rst_n(rst_n), .code_pulse_i(code_pulse), .event_pulse_i(ev_pulse),
    .tec_i(tec), .rec_i(rec), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq));

  task automatic check_reg(input logic [2:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: reg %0d got %02h expected %02h", tag, a, rdata, exp);
    end
  endtask

  task automatic check_irq(input logic exp, input string tag);
    n_chk++;
    if (irq !== exp) begin
      n_bad++;
      $display("FAIL %s: irq got %0b expected %0b", tag, irq, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse_code(input logic [6:0] p);
    @(negedge clk);
    code_pulse = p;
    @(negedge clk);
    code_pulse = '0;
  endtask

  task automatic set_cnt(input logic [8:0] t, input logic [7:0] r);
    @(negedge clk);
    tec = t; rec = r;
    @(negedge clk);
  endtask

  task automatic t_reset;
    for (int a = 0; a < 7; a++) check_reg(3'(a), 8'h00, "R1 reset");
    check_irq(1'b0, "R1 reset irq");
  endtask

  task automatic t_accumulate;
    wr(3'd0, 8'h80);
    pulse_code(7'h08);
    pulse_code(7'h01);
    check_reg(3'd0, 8'h89, "R3 accumulate");
    check_reg(3'd1, 8'h01, "R5 bus error flag");
  endtask

  task automatic t_clear;
    wr(3'd0, 8'hF7);
    check_reg(3'd0, 8'h81, "R2 code clear by zero");
    wr(3'd1, 8'hFF);
    check_reg(3'd1, 8'h01, "R2 factor write one keeps");
    wr(3'd1, 8'hFE);
    check_reg(3'd1, 8'h00, "R2 factor clear by zero");
  endtask

  task automatic t_latest;
    wr(3'd0, 8'h00);
    pulse_code(7'h04);
    check_reg(3'd0, 8'h04, "R4 latest first");
    pulse_code(7'h02);
    check_reg(3'd0, 8'h02, "R4 latest replaces");
    wr(3'd1, 8'h00);
  endtask

  task automatic t_thresholds;
    set_cnt(9'd95, 8'd0);
    check_reg(3'd1, 8'h00, "R6 below warning");
    set_cnt(9'd96, 8'd0);
    check_reg(3'd1, 8'h02, "R6 warning at 96");
    wr(3'd1, 8'h00);
    @(negedge clk);
    check_reg(3'd1, 8'h00, "R6 no retrigger while held");
    set_cnt(9'd127, 8'd0);
    check_reg(3'd1, 8'h00, "R7 not passive at 127");
    set_cnt(9'd128, 8'd0);
    check_reg(3'd1, 8'h04, "R7 passive above 127");
    wr(3'd1, 8'h00);
    set_cnt(9'd255, 8'd0);
    check_reg(3'd1, 8'h00, "R8 no busoff at 255");
    set_cnt(9'd256, 8'd0);
    check_reg(3'd1, 8'h08, "R8 busoff entry");
    check_reg(3'd5, 8'hFF, "R12 tec saturates");
    wr(3'd1, 8'h00);
    set_cnt(9'd0, 8'd0);
    check_reg(3'd1, 8'h10, "R8 busoff recovery");
    check_reg(3'd5, 8'h00, "R12 tec zero");
    wr(3'd1, 8'h00);
    set_cnt(9'd0, 8'd200);
    check_reg(3'd1, 8'h06, "R6 R7 from receive counter");
    check_reg(3'd6, 8'd200, "R12 rec readback");
    set_cnt(9'd100, 8'd0);
    check_reg(3'd5, 8'd100, "R12 tec readback");
    set_cnt(9'd0, 8'd0);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_events;
    @(negedge clk);
    ev_pulse = 3'b001;
    @(negedge clk);
    ev_pulse = 3'b110;
    @(negedge clk);
    ev_pulse = 3'b000;
    check_reg(3'd1, 8'hE0, "R9 overrun overload lock");
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    we = 1'b1; addr = 3'd1; wdata = 8'h00; ev_pulse = 3'b010;
    @(negedge clk);
    we = 1'b0; ev_pulse = 3'b000;
    check_reg(3'd1, 8'h40, "R10 factor set beats clear");
    wr(3'd0, 8'h80);
    @(negedge clk);
    we = 1'b1; addr = 3'd0; wdata = 8'h80; code_pulse = 7'h08;
    @(negedge clk);
    we = 1'b0; code_pulse = '0;
    check_reg(3'd0, 8'h88, "R10 code set beats clear");
  endtask

  task automatic t_irq;
    check_reg(3'd4, 8'h00, "R11 no enable no status");
    check_irq(1'b0, "R11 irq off");
    wr(3'd2, 8'h40);
    check_reg(3'd4, 8'h20, "R11 status set");
    check_irq(1'b0, "R11 irq gated");
    wr(3'd3, 8'h20);
    check_irq(1'b1, "R11 irq raised");
    wr(3'd1, 8'hBF);
    check_irq(1'b0, "R11 irq drops after clear");
    check_reg(3'd4, 8'h00, "R11 status clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_accumulate;
    t_clear;
    t_latest;
    t_thresholds;
    t_events;
    t_set_wins;
    t_irq;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule